// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Decimal Correction Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each clock cycle it takes an operation code, an accumulator operand and a memory operand. It registers an 8-bit result. When the flag write enable is high, it also updates four stored condition flags: half-carry (H), negative (N), zero (Z) and carry/borrow (C).

The unit supports binary add and subtract, in plain form and in a form that chains through the stored carry. It also has three bitwise logic operations, five shift and rotate forms, and a decimal-correction operation. Decimal correction turns the accumulator operand into a valid packed-BCD value after a BCD addition. It picks its correction from the stored H and C flags, so the host issues it right after an add that wrote the flags.

The block has no state machine. Its state is the registered result plus the four-bit flag register. An operation code is applied in cycle k, and the result and flags show it from the clock edge that ends cycle k.

Top module: `alu8_bcd`

## Requirements
- R1: Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 shift left, 8 logical shift right, 9 rotate left through carry, 10 rotate right through carry, 11 arithmetic shift right, 12 decimal adjust. The operand `acc_in` is the left-hand operand, and shifts act on `acc_in`. Add (0) gives acc+mem. Add-with-carry (1) gives acc+mem+C, where C is the stored carry. For both adds, C is set to the carry out of bit 7.
- R2: For codes 0 and 1, H is set when the low-nibble addition carries from bit 3 into bit 4, and cleared otherwise.
- R3: Every code other than 0 and 1 leaves H unchanged.
- R4: Subtract (2) gives acc-mem. Subtract-with-borrow (3) gives acc-mem-C. For both, C is set when a borrow is needed (the unsigned minuend is smaller than the subtrahend plus borrow-in), and cleared otherwise.
- R5: For codes 0 to 12, N is updated to bit 7 of the new result. Logical shift right therefore always clears N.
- R6: For codes 0 to 12, Z is set when the new 8-bit result is 0x00, and cleared otherwise.
- R7: AND, OR and XOR (4 to 6) leave C unchanged.
- R8: The shifts put the bit shifted out into C. Shift left (7) fills bit 0 with 0 and takes C from bit 7. Logical shift right (8) fills bit 7 with 0 and takes C from bit 0. Arithmetic shift right (11) copies bit 7 into itself and takes C from bit 0.
- R9: Rotate left (9) moves the old C into bit 0 and bit 7 into C. Rotate right (10) moves the old C into bit 7 and bit 0 into C.
- R10: Decimal adjust (12) adds 0x06 when the low nibble of acc is above 9 or H is set. It adds 0x60 when acc is above 0x99 or C is set. It sets C exactly when 0x60 was added.
- R11: With `flag_we` low, all four flags hold their values, while the result register still updates.
- R12: Codes 13 to 15 load the result with acc unchanged and leave all flags unchanged.
- R13: After reset the result is 0x00 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand (left-hand side) |
| mem_in | input | 8 | Memory operand (right-hand side) |
| flag_we | input | 1 | Enables the flag update in this cycle |
| result | output | 8 | Registered result |
| flag_h | output | 1 | Stored half-carry flag |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry/borrow flag |

## Verification
The only internal state is the four-bit flag register. A wrong stored C or H is not always visible on the next cycle. It shows up one operation later, as a wrong result from add-with-carry, subtract-with-borrow, a rotate, or decimal adjust. The bench therefore chains these operations directly after operations that set the flags, so that a corrupted flag shows at `result` within two cycles. Hold behaviour (write enable low, logic ops on C, non-add ops on H) is read straight from the flag outputs on the cycle after the operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_LSL = 4'd7,
        OP_LSR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_ASR = 4'd11,
        OP_DAA = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ROL = 3'd2,
        SH_ROR = 3'd3,
        SH_ASR = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic c;
    } ccr_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          carry_term,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          h_out
);
    logic [DW-1:0] b_eff;
    logic          cin;
    logic [DW:0]   full;
    logic [NW:0]   nib;

    always_comb begin
        b_eff = sub ? ~b : b;
        // subtraction runs as a + ~b + 1 - borrow
        cin   = sub ? ~carry_term : carry_term;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
        nib   = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin};
        sum   = full[DW-1:0];
        c_out = sub ? ~full[DW] : full[DW];
        h_out = nib[NW];
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          c_in,
    input  shift_kind_e   kind,
    output logic [DW-1:0] out,
    output logic          c_out
);
    always_comb begin
        unique case (kind)
            SH_LSL: begin out = {a[DW-2:0], 1'b0};   c_out = a[DW-1]; end
            SH_LSR: begin out = {1'b0, a[DW-1:1]};   c_out = a[0];    end
            SH_ROL: begin out = {a[DW-2:0], c_in};   c_out = a[DW-1]; end
            SH_ROR: begin out = {c_in, a[DW-1:1]};   c_out = a[0];    end
            SH_ASR: begin out = {a[DW-1], a[DW-1:1]}; c_out = a[0];   end
            default: begin out = a;                  c_out = c_in;    end
        endcase
    end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          h_in,
    input  logic          c_in,
    output logic [DW-1:0] out,
    output logic          c_out
);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);
    localparam logic [NW-1:0] NIB_FIX = NW'(6);
    localparam logic [DW-1:0] BYTE_MAX = {NIB_MAX, NIB_MAX};

    logic lo_fix;
    logic hi_fix;

    always_comb begin
        lo_fix = (a[NW-1:0] > NIB_MAX) | h_in;
        hi_fix = (a > BYTE_MAX) | c_in;
        out    = a + {(hi_fix ? NIB_FIX : {NW{1'b0}}),
                      (lo_fix ? NIB_FIX : {NW{1'b0}})};
        c_out  = hi_fix;
    end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [7:0]    acc_in,
    input  logic [7:0]    mem_in,
    input  logic          flag_we,
    output logic [7:0]    result,
    output logic          flag_h,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c
);
    ccr_t          ccr_q;
    ccr_t          ccr_d;
    logic [DW-1:0] res_q;
    logic [DW-1:0] res_d;

    alu_op_e       op;
    logic          as_sub;
    logic          as_carry;
    logic [DW-1:0] as_sum;
    logic          as_c;
    logic          as_h;
    shift_kind_e   sh_kind;
    logic [DW-1:0] sh_out;
    logic          sh_c;
    logic [DW-1:0] da_out;
    logic          da_c;

    always_comb begin
        op       = alu_op_e'(op_sel);
        as_sub   = (op == OP_SUB) || (op == OP_SBC);
        as_carry = ((op == OP_ADC) || (op == OP_SBC)) ? ccr_q.c : 1'b0;
        unique case (op)
            OP_LSR:  sh_kind = SH_LSR;
            OP_ROL:  sh_kind = SH_ROL;
            OP_ROR:  sh_kind = SH_ROR;
            OP_ASR:  sh_kind = SH_ASR;
            default: sh_kind = SH_LSL;
        endcase
    end

    alu8_addsub u_addsub (
        .a(acc_in), .b(mem_in), .sub(as_sub), .carry_term(as_carry),
        .sum(as_sum), .c_out(as_c), .h_out(as_h)
    );

    alu8_shift u_shift (
        .a(acc_in), .c_in(ccr_q.c), .kind(sh_kind),
        .out(sh_out), .c_out(sh_c)
    );

    alu8_daa u_daa (
        .a(acc_in), .h_in(ccr_q.h), .c_in(ccr_q.c),
        .out(da_out), .c_out(da_c)
    );

    always_comb begin
        ccr_d = ccr_q;
        res_d = acc_in;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res_d   = as_sum;
                ccr_d.c = as_c;
                ccr_d.h = as_h;
            end
            OP_SUB, OP_SBC: begin
                res_d   = as_sum;
                ccr_d.c = as_c;
            end
            OP_AND: res_d = acc_in & mem_in;
            OP_OR:  res_d = acc_in | mem_in;
            OP_XOR: res_d = acc_in ^ mem_in;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res_d   = sh_out;
                ccr_d.c = sh_c;
            end
            OP_DAA: begin
                res_d   = da_out;
                ccr_d.c = da_c;
            end
            default: res_d = acc_in;
        endcase
        if (op_sel <= OPW'(OP_DAA)) begin
            ccr_d.n = res_d[DW-1];
            ccr_d.z = (res_d == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            ccr_q <= '0;
        end else begin
            res_q <= res_d;
            if (flag_we) ccr_q <= ccr_d;
        end
    end

    assign result = res_q;
    assign flag_h = ccr_q.h;
    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_c = ccr_q.c;
endmodule

// File: rtl/alu8_bcd_checker.sv
module alu8_bcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] mem_in,
    input logic       flag_we,
    input logic [7:0] result,
    input logic       flag_h,
    input logic       flag_n,
    input logic       flag_z,
    input logic       flag_c
);
    assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 4'd0) |=>
            (flag_c == (({1'b0, $past(acc_in)} + {1'b0, $past(mem_in)}) > 9'h0ff)));

    assert_half_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd1) |=> $stable(flag_h));

    assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel <= 4'd12) |=> (flag_n == result[7]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel <= 4'd12) |=> (flag_z == (result == 8'h00)));

    assert_logic_keeps_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd4 && op_sel <= 4'd6) |=> $stable(flag_c));

    assert_we_low_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we) |=> $stable({flag_h, flag_n, flag_z, flag_c}));

    assert_undef_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd12) |=> (result == $past(acc_in)));
endmodule

bind alu8_bcd alu8_bcd_checker u_alu8_bcd_checker (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in),
    .mem_in(mem_in), .flag_we(flag_we), .result(result),
    .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/test_alu8_bcd.sv
module test_alu8_bcd;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] mem_in = 8'h00;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic       flag_h, flag_n, flag_z, flag_c;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench copy of the stored flags
    bit mh, mn, mz, mc;

    always #10 clk = ~clk;

    alu8_bcd i_alu8_bcd (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in),
        .mem_in(mem_in), .flag_we(flag_we), .result(result),
        .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // apply one operation; compute expected from the requirement text
    task automatic run_op(input string req, input int op, input int a, input int m, input bit we);
        int  r;
        bit  nh, nc;
        int  full;
        bit  defined;
        nh = mh; nc = mc; r = a; defined = (op <= 12);
        case (op)
            0, 1: begin
                full = a + m + ((op == 1) ? int'(mc) : 0);
                r  = full & 8'hff; nc = (full > 255);
                nh = (((a & 15) + (m & 15) + ((op == 1) ? int'(mc) : 0)) > 15);
            end
            2, 3: begin
                full = a - m - ((op == 3) ? int'(mc) : 0);
                nc = (full < 0); r = full & 8'hff;
            end
            4: r = a & m;
            5: r = a | m;
            6: r = a ^ m;
            7: begin r = (a * 2) & 8'hff; nc = a[7]; end
            8: begin r = a / 2; nc = a[0]; end
            9: begin r = ((a * 2) & 8'hff) | int'(mc); nc = a[7]; end
            10: begin r = (a / 2) | (mc ? 128 : 0); nc = a[0]; end
            11: begin r = (a / 2) | (a & 128); nc = a[0]; end
            12: begin
                int corr;
                corr = 0;
                if ((a & 15) > 9 || mh) corr += 6;
                if (a > 153 || mc) begin corr += 96; nc = 1; end else nc = 0;
                r = (a + corr) & 8'hff;
            end
            default: r = a;
        endcase
        @(negedge clk);
        op_sel = 4'(op); acc_in = 8'(a); mem_in = 8'(m); flag_we = we;
        @(negedge clk);
        if (we && defined) begin
            mh = nh; mc = nc; mn = r[7]; mz = (r == 0);
        end
        chk(req, "result", int'(result), r);
        chk(req, "H", int'(flag_h), int'(mh));
        chk(req, "N", int'(flag_n), int'(mn));
        chk(req, "Z", int'(flag_z), int'(mz));
        chk(req, "C", int'(flag_c), int'(mc));
    endtask

    task automatic t_reset_R13();
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R13", "result", int'(result), 0);
        chk("R13", "flags", int'({flag_h, flag_n, flag_z, flag_c}), 0);
        mh = 0; mn = 0; mz = 0; mc = 0;
        rst_n = 1;
    endtask

    task automatic t_add_R1_R2();
        run_op("R1", 0, 8'h3c, 8'h11, 1);
        run_op("R2", 0, 8'h08, 8'h08, 1);
        chk("R2", "H after 08+08", int'(flag_h), 1);
        run_op("R1", 0, 8'hf0, 8'h20, 1);
        chk("R1", "C after f0+20", int'(flag_c), 1);
        run_op("R1", 1, 8'h01, 8'h01, 1);
        chk("R1", "adc uses C", int'(result), 8'h03);
        run_op("R6", 0, 8'h80, 8'h80, 1);
        chk("R6", "Z on 80+80", int'(flag_z), 1);
    endtask

    task automatic t_sub_R4();
        run_op("R4", 2, 8'h10, 8'h20, 1);
        chk("R4", "borrow", int'(flag_c), 1);
        run_op("R4", 3, 8'h50, 8'h10, 1);
        chk("R4", "sbc uses C", int'(result), 8'h3f);
        run_op("R4", 3, 8'h05, 8'h05, 1);
        run_op("R5", 2, 8'h00, 8'h01, 1);
        chk("R5", "N on ff", int'(flag_n), 1);
        run_op("R3", 2, 8'h00, 8'h00, 1);
    endtask

    task automatic t_logic_R7();
        run_op("R7", 2, 8'h00, 8'h01, 1);
        run_op("R7", 4, 8'hf0, 8'h0f, 1);
        chk("R7", "C kept after and", int'(flag_c), 1);
        run_op("R7", 5, 8'h81, 8'h02, 1);
        run_op("R7", 6, 8'haa, 8'haa, 1);
    endtask

    task automatic t_shift_R8_R9();
        run_op("R8", 7, 8'h81, 8'h00, 1);
        run_op("R8", 8, 8'h81, 8'h00, 1);
        run_op("R8", 11, 8'h81, 8'h00, 1);
        chk("R8", "asr keeps sign", int'(result), 8'hc0);
        run_op("R9", 9, 8'h40, 8'h00, 1);
        chk("R9", "rol carry in", int'(result), 8'h81);
        run_op("R9", 10, 8'h02, 8'h00, 1);
        run_op("R9", 10, 8'h01, 8'h00, 1);
        run_op("R9", 9, 8'h00, 8'h00, 1);
    endtask

    task automatic t_daa_R10();
        run_op("R10", 0, 8'h15, 8'h27, 1);
        run_op("R10", 12, int'(result), 8'h00, 1);
        chk("R10", "15+27", int'(result), 8'h42);
        run_op("R10", 0, 8'h08, 8'h08, 1);
        run_op("R10", 12, int'(result), 8'h00, 1);
        chk("R10", "08+08", int'(result), 8'h16);
        run_op("R10", 0, 8'h99, 8'h01, 1);
        run_op("R10", 12, int'(result), 8'h00, 1);
        chk("R10", "99+01 wraps", int'(result), 8'h00);
        chk("R10", "99+01 carry", int'(flag_c), 1);
        run_op("R10", 0, 8'h90, 8'h90, 1);
        run_op("R10", 12, int'(result), 8'h00, 1);
    endtask

    task automatic t_hold_R11_R12();
        run_op("R11", 0, 8'hff, 8'h01, 1);
        run_op("R11", 2, 8'h01, 8'h00, 0);
        chk("R11", "result still updates", int'(result), 8'h01);
        run_op("R11", 7, 8'h01, 8'h00, 0);
        run_op("R12", 13, 8'h5a, 8'h00, 1);
        run_op("R12", 15, 8'h00, 8'hff, 1);
        chk("R12", "flags kept", int'({flag_z, flag_c}), 3);
    endtask

    initial begin
        t_reset_R13();
        t_add_R1_R2();
        t_sub_R4();
        t_logic_R7();
        t_shift_R8_R9();
        t_daa_R10();
        t_hold_R11_R12();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule